// File: doc/BRIEF.md
# Serial Link Shift Port

This block is a byte-wide serial port that a CPU drives through two registers. One register holds the byte being exchanged. The other controls the transfer: a busy/request flag in bit 7, an enhanced-rate select in bit 1 and a clock-source select in bit 0. When the CPU requests a transfer that uses the internal clock, the port shifts the data register out most-significant bit first. Once per bit period it takes one bit from the link input. After the eighth bit it clears the busy flag and pulses an interrupt request.

The transfer is timed against a free-running cycle count. The start point is rounded down to a coarse boundary, so the first bit ends one full bit period after that boundary. The bit period is 512 cycles at the normal rate. When the enhanced mode is enabled and bit 1 is set, the period is 16 cycles. A transfer can also finish from outside: a byte delivered by a link partner while the busy flag is set replaces the data register and ends the transfer at once.

Top module: `serial_link_port`

## Requirements
- R1: A control write with bit 7 and bit 0 both 1 starts an internal-clock transfer of exactly 8 bit periods. The bit count reloads to 8 even if a transfer is already running.
- R2: At the normal rate (bit period 512), a start written in counter cycle c completes on the clock edge at counter value a+4096, where a is c rounded down to a multiple of 256. The counter starts at 0 on the first edge after reset release.
- R3: When the enhanced-mode input is 1 and control bit 1 is written as 1, the bit period is 16. Completion comes at a+128, where a is c rounded down to a multiple of 8.
- R4: When the enhanced-mode input is 0, control bit 1 has no effect on timing: the transfer uses the normal rate.
- R5: On each bit boundary the data register shifts left by one and takes the link input into bit 0. A link input held at 1 therefore fills the register with ones. A mid-transfer read returns the partly shifted value.
- R6: On completion, control bit 7 reads 0 and the interrupt output is high for exactly one cycle, in the cycle after the completing edge.
- R7: A control write that does not have both bit 7 and bit 0 set cancels a running transfer. No interrupt follows, and the data register stops shifting.
- R8: An external byte delivered while control bit 7 is 1 is loaded into the data register, clears bit 7 and raises the interrupt. When bit 7 is 0, the delivery is ignored.
- R9: The control register reads back bits 7, 1 and 0 as stored and all other bits as 1. When the enhanced-mode input is 0, bit 1 also reads as 1.
- R10: The serial data output equals data bit 7. The serial clock output is high when idle and low during the first half of each bit period of a transfer.
- R11: After reset the data register reads 0x00, the control register reads 0x7E and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_mode_i | input | 1 | Enhanced mode enable (allows fast rate) |
| wr_en_i | input | 1 | Register write strobe |
| sel_ctrl_i | input | 1 | Register select: 0 data, 1 control |
| wdata_i | input | 8 | Write data |
| data_q_o | output | 8 | Data register read value |
| ctrl_q_o | output | 8 | Control register read value |
| irq_o | output | 1 | Serial interrupt request pulse |
| sclk_o | output | 1 | Serial clock output |
| sout_o | output | 1 | Serial data output |
| sin_i | input | 1 | Serial data input (1 when unconnected) |
| ext_valid_i | input | 1 | External byte delivery strobe |
| ext_byte_i | input | 8 | Externally delivered byte |

## Verification
The hardest case to reach from the ports is the exact completion edge relative to the alignment boundary. The 256-cycle rounding only shows when a start lands at many different offsets inside a boundary window. The stimulus waits on a bench-side copy of the cycle count, issues starts at chosen offsets for both rates, and checks the interrupt and busy flag on both sides of the predicted completion edge. Cancellation is reached by a control write placed between two bit boundaries, and the data value left behind is checked.

// File: rtl/serial_link_pkg.sv
package serial_link_pkg;
  typedef enum logic {SEL_DATA = 1'b0, SEL_CTRL = 1'b1} reg_sel_t;
  localparam int unsigned CTRL_BUSY = 7;
  localparam int unsigned CTRL_FAST = 1;
  localparam int unsigned CTRL_INTCLK = 0;
endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/slp_timebase.sv
module slp_timebase #(
  parameter int unsigned NORM_BIT   = 512,
  parameter int unsigned NORM_ALIGN = 256,
  parameter int unsigned FAST_BIT   = 16,
  parameter int unsigned FAST_ALIGN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fast_i,
  input  logic run_i,
  output logic tick_o,
  output logic sclk_o
);
  localparam int unsigned CW = $clog2(NORM_BIT);
  localparam logic [CW-1:0] N_MASK = CW'(NORM_BIT - 1);
  localparam logic [CW-1:0] F_MASK = CW'(FAST_BIT - 1);
  localparam logic [CW-1:0] N_ALN  = ~CW'(NORM_ALIGN - 1) & N_MASK;
  localparam logic [CW-1:0] F_ALN  = ~CW'(FAST_ALIGN - 1) & F_MASK;
  localparam logic [CW-1:0] N_HALF = CW'(NORM_BIT / 2);
  localparam logic [CW-1:0] F_HALF = CW'(FAST_BIT / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] phase_q, phase_d;
  logic          fast_q, fast_d;
  logic [CW-1:0] mask, half, sub;

  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    phase_d = phase_q;
    fast_d  = fast_q;
    if (start_i) begin
      phase_d = cnt_q & (fast_i ? F_ALN : N_ALN);
      fast_d  = fast_i;
    end
    mask   = fast_q ? F_MASK : N_MASK;
    half   = fast_q ? F_HALF : N_HALF;
    sub    = (cnt_q - phase_q) & mask;
    tick_o = run_i && !start_i && ((cnt_q & mask) == phase_q);
    sclk_o = !run_i || (sub >= half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
      fast_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      fast_q  <= fast_d;
    end
  end
endmodule

// File: rtl/serial_link_port.sv
module serial_link_port
  import serial_link_pkg::*;
#(
  parameter int unsigned NBITS      = 8,
  parameter int unsigned NORM_BIT   = 512,
  parameter int unsigned NORM_ALIGN = 256,
  parameter int unsigned FAST_BIT   = 16,
  parameter int unsigned FAST_ALIGN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enh_mode_i,
  input  logic       wr_en_i,
  input  logic       sel_ctrl_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] data_q_o,
  output logic [7:0] ctrl_q_o,
  output logic       irq_o,
  output logic       sclk_o,
  output logic       sout_o,
  input  logic       sin_i,
  input  logic       ext_valid_i,
  input  logic [7:0] ext_byte_i
);
  localparam int unsigned BW = $clog2(NBITS + 1);

  logic rst_q_n;
  logic busy_q, busy_d, fast_q, fast_d, intclk_q, intclk_d;
  logic active_q, active_d, irq_q, irq_d;
  logic [7:0] data_q, data_d;
  logic [BW-1:0] bits_q, bits_d;
  logic wr_ctrl, wr_data, start, stop, ext_take, tick;

  slp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  assign wr_ctrl  = wr_en_i && (reg_sel_t'(sel_ctrl_i) == SEL_CTRL);
  assign wr_data  = wr_en_i && (reg_sel_t'(sel_ctrl_i) == SEL_DATA);
  assign start    = wr_ctrl && wdata_i[CTRL_BUSY] && wdata_i[CTRL_INTCLK];
  assign stop     = wr_ctrl && !start;
  assign ext_take = ext_valid_i && busy_q;

  slp_timebase #(
    .NORM_BIT(NORM_BIT), .NORM_ALIGN(NORM_ALIGN),
    .FAST_BIT(FAST_BIT), .FAST_ALIGN(FAST_ALIGN)
  ) u_tb (
    .clk(clk), .rst_n(rst_q_n), .start_i(start),
    .fast_i(enh_mode_i && wdata_i[CTRL_FAST]),
    .run_i(active_q), .tick_o(tick), .sclk_o(sclk_o)
  );

  always_comb begin
    busy_d   = busy_q;
    fast_d   = fast_q;
    intclk_d = intclk_q;
    active_d = active_q;
    data_d   = data_q;
    bits_d   = bits_q;
    irq_d    = 1'b0;
    if (wr_ctrl) begin
      busy_d   = wdata_i[CTRL_BUSY];
      fast_d   = wdata_i[CTRL_FAST];
      intclk_d = wdata_i[CTRL_INTCLK];
      active_d = start;
      if (start) bits_d = BW'(NBITS);
    end else if (ext_take) begin
      data_d   = ext_byte_i;
      busy_d   = 1'b0;
      active_d = 1'b0;
      irq_d    = 1'b1;
    end else if (tick) begin
      data_d = {data_q[6:0], sin_i};
      bits_d = bits_q - 1'b1;
      if (bits_q == BW'(1)) begin
        active_d = 1'b0;
        busy_d   = 1'b0;
        irq_d    = 1'b1;
      end
    end
    if (wr_data) data_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q   <= 1'b0;
      fast_q   <= 1'b0;
      intclk_q <= 1'b0;
      active_q <= 1'b0;
      data_q   <= '0;
      bits_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      fast_q   <= fast_d;
      intclk_q <= intclk_d;
      active_q <= active_d;
      data_q   <= data_d;
      bits_q   <= bits_d;
      irq_q    <= irq_d;
    end
  end

  assign data_q_o = data_q;
  assign ctrl_q_o = enh_mode_i ? {busy_q, 5'h1F, fast_q, intclk_q}
                               : {busy_q, 6'h3F, intclk_q};
  assign irq_o    = irq_q;
  assign sout_o   = data_q[7];

  p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    start |=> (active_q && bits_q == BW'(NBITS)));
  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tick && bits_q == BW'(1) && !wr_en_i) |=> (irq_o && !busy_q && !active_q));
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_o |=> !irq_o);
  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    stop |=> !active_q);
  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tick && !wr_en_i && !ext_take) |=> data_q == {$past(data_q[6:0]), $past(sin_i)});
  p_ext_load_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ext_take && !wr_en_i) |=> (data_q == $past(ext_byte_i) && !busy_q && irq_o));
  p_ext_ignore_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ext_valid_i && !busy_q && !wr_en_i && !active_q) |=> $stable(data_q));
endmodule

// File: tb/tb_serial_link_port.sv
`timescale 1ns/100ps
module tb_serial_link_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enh = 1'b0, wr = 1'b0, sel = 1'b0, sin = 1'b1, extv = 1'b0;
  logic [7:0] wd = '0, extb = '0;
  logic [7:0] dq, cq;
  logic irq, sclk, sout;
  int tests = 0, fails = 0, ecount = 0, irq_cnt = 0;

  always #2.5 clk = ~clk;

  serial_link_port dut (
    .clk(clk), .rst_n(rst_n), .enh_mode_i(enh), .wr_en_i(wr), .sel_ctrl_i(sel),
    .wdata_i(wd), .data_q_o(dq), .ctrl_q_o(cq), .irq_o(irq), .sclk_o(sclk),
    .sout_o(sout), .sin_i(sin), .ext_valid_i(extv), .ext_byte_i(extb)
  );

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;
  always @(negedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  function automatic int now();
    return ecount - 2;
  endfunction

  function automatic int ctrl_rd(logic e, int v);
    return e ? ((v & 8'h83) | 8'h7C) : ((v & 8'h81) | 8'h7E);
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic s, logic [7:0] v);
    wr = 1'b1; sel = s; wd = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_to(int t);
    while (now() < t) @(negedge clk);
  endtask

  // Full internal-clock transfer, start placed at offset off inside the align window
  task automatic run_xfer(logic e, logic fastbit, int off, logic s, logic [7:0] init, bit mid);
    int P, AL, c, a, E, ex, ic;
    logic fast;
    fast = e && fastbit;
    P  = fast ? 16 : 512;
    AL = fast ? 8 : 256;
    enh = e; sin = s;
    wreg(1'b0, init);
    while ((now() % AL) != off) @(negedge clk);
    c = now();
    a = c - (c % AL);
    E = a + 8 * P;
    wreg(1'b1, {1'b1, 5'b0, fastbit, 1'b1});
    if (mid) begin
      wait_to(a + P + 1);
      chk("R10 sclk low early in bit", sclk, 0);
      wait_to(a + P + P/2 + 1);
      chk("R10 sclk high late in bit", sclk, 1);
      wait_to(a + 4*P + 1);
      ex = ((init << 4) | (s ? 8'h0F : 8'h00)) & 8'hFF;
      chk("R5 partial shift read", dq, ex);
      chk("R10 sout is msb", sout, (ex >> 7) & 1);
    end
    wait_to(E);
    ic = irq_cnt;
    chk("R2/R3 no irq before completion edge", irq, 0);
    chk("R1 busy still set before completion", cq[7], 1);
    wait_to(E + 1);
    chk(fast ? "R3 irq at fast completion" : "R2 irq at normal completion", irq, 1);
    chk("R6 busy cleared", cq, ctrl_rd(e, {1'b0, 5'b0, fastbit, 1'b1}));
    chk("R5 fill result", dq, s ? 8'hFF : 8'h00);
    wait_to(E + 2);
    chk("R6 irq one cycle", irq, 0);
    chk("R6 single irq", irq_cnt - ic, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c, a, ic;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 data reset", dq, 8'h00);
    chk("R11 ctrl reset", cq, 8'h7E);
    chk("R11 irq reset", irq, 0);
    chk("R10 sclk idle high", sclk, 1);

    // R9 readback sweep over the stored bits in both modes (no start: bit7&bit0 never both set)
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 8; v++) begin
        logic [7:0] w;
        w = {v[2], 5'b0, v[1], v[0]};
        if (w[7] && w[0]) continue;
        enh = m[0];
        wreg(1'b1, w | 8'h7C);
        chk("R9 control readback", cq, ctrl_rd(m[0], w));
      end
    end
    wreg(1'b1, 8'h00);

    // R8 external byte with busy clear is ignored
    wreg(1'b0, 8'hA5);
    ic = irq_cnt;
    extv = 1'b1; extb = 8'h3C; @(negedge clk); extv = 1'b0;
    @(negedge clk);
    chk("R8 ignored ext data", dq, 8'hA5);
    chk("R8 ignored ext no irq", irq_cnt - ic, 0);
    // R8 external byte while waiting on external clock
    enh = 1'b0;
    wreg(1'b1, 8'h80);
    chk("R9 busy ext-clock readback", cq, 8'hFE);
    extv = 1'b1; extb = 8'h3C; @(negedge clk); extv = 1'b0;
    chk("R8 ext data loaded", dq, 8'h3C);
    chk("R8 ext irq", irq, 1);
    chk("R8 ext clears busy", cq, 8'h7E);
    @(negedge clk);
    chk("R6 ext irq single cycle", irq, 0);

    // Normal rate at several offsets, first one with mid-transfer probes
    run_xfer(1'b0, 1'b0, 0,   1'b1, 8'h5A, 1'b1);
    run_xfer(1'b0, 1'b0, 1,   1'b0, 8'hC3, 1'b0);
    run_xfer(1'b0, 1'b0, 137, 1'b1, 8'h00, 1'b0);
    run_xfer(1'b0, 1'b0, 255, 1'b1, 8'h81, 1'b0);
    // R4 fast bit ignored outside enhanced mode
    run_xfer(1'b0, 1'b1, 200, 1'b1, 8'h12, 1'b0);
    // R3 fast rate sweep over all alignment offsets
    for (int o = 0; o < 8; o++) run_xfer(1'b1, 1'b1, o, o[0], 8'h69, o == 3);
    // enhanced mode with bit1 clear stays normal rate
    run_xfer(1'b1, 1'b0, 64, 1'b1, 8'h44, 1'b0);

    // R7 cancel after two bit periods
    enh = 1'b0; sin = 1'b1;
    wreg(1'b0, 8'h5A);
    while ((now() % 256) != 10) @(negedge clk);
    c = now(); a = c - 10;
    wreg(1'b1, 8'h81);
    wait_to(a + 2*512 + 1);
    chk("R5 two bits shifted", dq, 8'h6B);
    ic = irq_cnt;
    wreg(1'b1, 8'h01);
    wait_to(a + 8*512 + 3);
    chk("R7 no irq after cancel", irq_cnt - ic, 0);
    chk("R7 data frozen", dq, 8'h6B);
    chk("R7 ctrl after cancel", cq, 8'h7F);

    // R1 restart mid-transfer reloads the bit count
    enh = 1'b1;
    wreg(1'b0, 8'h00);
    while ((now() % 8) != 0) @(negedge clk);
    wreg(1'b1, 8'h83);
    wait_to(now() + 40);
    c = now(); a = c - (c % 8);
    ic = irq_cnt;
    wreg(1'b1, 8'h83);
    wait_to(a + 128);
    chk("R1 restart no early irq", irq_cnt - ic, 0);
    wait_to(a + 129);
    chk("R1 restart completes 8 periods later", irq, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule